// File: doc/BRIEF.md
# Regulator Enable Sequencer

This block is the digital controller that decides, cycle by cycle, which of six on-chip supply regulators are switched on. It owns the enables for a buck converter, a system LDO, a core LDO, a main I/O LDO, a standby I/O LDO and a retention LDO. On a wakeup request it brings up a startup set of regulators chosen by a 2-bit power mode. It then waits for the main I/O supply to settle before it lets go of the standby I/O supply. It finally waits for a startup-done indication, which for one mode also retires the system LDO.

On a sleep request the block drops every regulator whose sleep turn-off bit is set. When the main I/O supply is to be turned off and standby takeover is requested, the block first raises the standby I/O LDO and waits for it to report stable before it drops the main I/O LDO. Software can set or clear any hardware enable with one-cycle pulses. It can also force any output through an override-enable and override-value pair, and it reads the driven enables back. A regulator's stable indication counts only after four consecutive high cycles. A programmable timeout on each stable wait latches an error and freezes the sequencer.

Enable bit order, used by every 6-bit vector on the ports: bit 0 buck, bit 1 system LDO, bit 2 core LDO, bit 3 main I/O LDO, bit 4 standby I/O LDO, bit 5 retention LDO.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the driven enables are 6'b100000 (only the retention LDO on), `asleep` is 1, `active` is 0 and `seq_err` is 0.
- R2: A wakeup request while asleep turns the buck on for power modes 0, 2 and 3 and off for mode 1. It turns the system LDO on for modes 1, 2 and 3 and off for mode 0.
- R3: In the startup phase a `start_done` pulse makes the block active. In power mode 2 the same pulse turns the system LDO off; in mode 3 both the buck and the system LDO stay on.
- R4: A wakeup request always turns on the core LDO and the main I/O LDO, in every power mode.
- R5: A set pulse turns a hardware enable on and a clear pulse turns it off. The driven output follows two clock edges after the pulse. A set and a clear for the same regulator in the same cycle leave it off.
- R6: A sleep request while active, without standby takeover, clears every enable whose `slp_off` bit is 1 and makes `asleep` 1.
- R7: A sleep request with `slp_off[3]`=1 and `stb_on_cfg`=1 first turns the standby I/O LDO on. The main I/O LDO and the other `slp_off` enables stay on until the standby LDO is filtered-stable; then they drop and `asleep` becomes 1.
- R8: During wakeup the standby I/O LDO stays on until the main I/O LDO is filtered-stable. Only then is it released.
- R9: A stable input counts only after it has been high for 4 consecutive clock cycles; a shorter high run is ignored.
- R10: If a stable wait lasts more than `tmo_limit`+1 cycles, `seq_err` becomes 1 and stays 1. The sequencer then ignores wakeup, sleep and startup-done inputs, and its state and enables are frozen.
- R11: When `ovr_en[i]` is 1, `en_out[i]` equals `ovr_val[i]` from the next clock edge. When `ovr_en[i]` is 0, `en_out[i]` follows the hardware enable.
- R12: `en_rdbk` always equals the enables driven on `en_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_req | input | 1 | Wakeup request pulse |
| sleep_req | input | 1 | Sleep-entry request pulse |
| start_done | input | 1 | Startup complete indication |
| pmode | input | 2 | Startup power mode |
| set_pls | input | 6 | Per-regulator enable set pulses |
| clr_pls | input | 6 | Per-regulator enable clear pulses |
| slp_off | input | 6 | Per-regulator turn-off-at-sleep configuration |
| stb_on_cfg | input | 1 | Request standby I/O takeover at sleep |
| reg_stable | input | 6 | Stable indications from the regulators |
| tmo_limit | input | TMO_W | Stable-wait timeout limit in cycles |
| ovr_en | input | 6 | Per-regulator override enable |
| ovr_val | input | 6 | Per-regulator override value |
| en_out | output | 6 | Registered enables driven to the regulators |
| en_rdbk | output | 6 | Readback of the driven enables |
| asleep | output | 1 | Sequencer is in the sleep state |
| active | output | 1 | Sequencer is in the active state |
| seq_err | output | 1 | Sticky stable-wait timeout error |

## Verification
Two functions can meet in the same cycle: a software set pulse and a software clear pulse aimed at the same regulator. The bench provokes this on the core LDO while the block is active. It drives both pulses on one negative edge, then samples `en_out` two edges later and expects the bit off. A clear on its own and a set on its own are also checked, so a design that lets the set win, or that ignores one of the pulses, is caught.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int STB_FILT = 4,
  parameter int TMO_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake_req,
  input  logic             sleep_req,
  input  logic             start_done,
  input  logic [1:0]       pmode,
  input  logic [5:0]       set_pls,
  input  logic [5:0]       clr_pls,
  input  logic [5:0]       slp_off,
  input  logic             stb_on_cfg,
  input  logic [5:0]       reg_stable,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [5:0]       ovr_en,
  input  logic [5:0]       ovr_val,
  output logic [5:0]       en_out,
  output logic [5:0]       en_rdbk,
  output logic             asleep,
  output logic             active,
  output logic             seq_err
);
  localparam int NREG = 6;
  localparam int FW   = $clog2(STB_FILT + 1);
  localparam int BUCK = 0;
  localparam int SYS  = 1;
  localparam int CORE = 2;
  localparam int MIO  = 3;
  localparam int STB  = 4;
  localparam logic [NREG-1:0] RST_EN  = 6'b100000;
  localparam logic [NREG-1:0] STB_BIT = 6'b010000;

  typedef enum logic [2:0] {S_SLEEP, S_WAKE_IO, S_WAKE_ST, S_ACTIVE, S_SLP_STB} st_t;

  st_t              st, nx_st;
  logic [NREG-1:0]  hw_en, nx_hw, ok;
  logic [TMO_W-1:0] tmo_cnt;
  logic             waiting;

  for (genvar i = 0; i < NREG; i++) begin : g_filt
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!reg_stable[i]) cnt <= '0;
      else if (cnt != FW'(STB_FILT)) cnt <= cnt + 1'b1;
    end
    assign ok[i] = (cnt == FW'(STB_FILT));
  end

  always_comb begin
    nx_hw = (hw_en | set_pls) & ~clr_pls;
    nx_st = st;
    if (!seq_err) begin
      unique case (st)
        S_SLEEP: if (wake_req) begin
          nx_hw[CORE] = 1'b1;
          nx_hw[MIO]  = 1'b1;
          nx_hw[BUCK] = (pmode != 2'd1);
          nx_hw[SYS]  = (pmode != 2'd0);
          nx_st       = S_WAKE_IO;
        end
        S_WAKE_IO: if (ok[MIO]) begin
          nx_hw[STB] = 1'b0;
          nx_st      = S_WAKE_ST;
        end
        S_WAKE_ST: if (start_done) begin
          if (pmode == 2'd2) nx_hw[SYS] = 1'b0;
          nx_st = S_ACTIVE;
        end
        S_ACTIVE: if (sleep_req) begin
          if (slp_off[MIO] && stb_on_cfg) begin
            nx_hw[STB] = 1'b1;
            nx_st      = S_SLP_STB;
          end else begin
            nx_hw = nx_hw & ~slp_off;
            nx_st = S_SLEEP;
          end
        end
        S_SLP_STB: if (ok[STB]) begin
          nx_hw = nx_hw & ~(slp_off & ~STB_BIT);
          nx_st = S_SLEEP;
        end
        default: nx_st = S_SLEEP;
      endcase
    end
  end

  assign waiting = ((st == S_WAKE_IO) && !ok[MIO]) || ((st == S_SLP_STB) && !ok[STB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_SLEEP;
      hw_en   <= RST_EN;
      en_out  <= RST_EN;
      tmo_cnt <= '0;
      seq_err <= 1'b0;
    end else begin
      st     <= nx_st;
      hw_en  <= nx_hw;
      en_out <= (ovr_en & ovr_val) | (~ovr_en & hw_en);
      if (seq_err) begin
        tmo_cnt <= tmo_cnt;
      end else if (!waiting) begin
        tmo_cnt <= '0;
      end else if (tmo_cnt == tmo_limit) begin
        seq_err <= 1'b1;
      end else begin
        tmo_cnt <= tmo_cnt + 1'b1;
      end
    end
  end

  assign en_rdbk = en_out;
  assign asleep  = (st == S_SLEEP);
  assign active  = (st == S_ACTIVE);
endmodule

module pwr_seq_ctrl_chk #(
  parameter int STB_FILT = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] clr_pls,
  input logic [5:0] ovr_en,
  input logic [5:0] ovr_val,
  input logic [5:0] reg_stable,
  input logic [5:0] hw_en,
  input logic [5:0] en_out,
  input logic       sleep_req,
  input logic       asleep,
  input logic       active,
  input logic       seq_err
);
  localparam int FW = $clog2(STB_FILT + 1);
  logic          armed;
  logic [FW-1:0] stb_run, mio_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      stb_run <= '0;
      mio_run <= '0;
    end else begin
      armed   <= 1'b1;
      stb_run <= !reg_stable[4] ? '0 : (stb_run == FW'(STB_FILT) ? stb_run : stb_run + 1'b1);
      mio_run <= !reg_stable[3] ? '0 : (mio_run == FW'(STB_FILT) ? mio_run : mio_run + 1'b1);
    end
  end

  p_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && active && !sleep_req |=> (hw_en & $past(clr_pls)) == 6'b0);

  p_ovr_val_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ((en_out ^ $past(ovr_val)) & $past(ovr_en)) == 6'b0);

  p_hw_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ((en_out ^ $past(hw_en)) & ~$past(ovr_en)) == 6'b0);

  p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(hw_en[3]) && hw_en[4] && !$past(clr_pls[3]) && !$past(active)
    |-> $past(stb_run) == FW'(STB_FILT));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(hw_en[4]) && !$past(clr_pls[4]) && !$past(active) && !asleep
    |-> $past(mio_run) == FW'(STB_FILT));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err && $stable(asleep) && $stable(active));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.STB_FILT(STB_FILT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_pls(clr_pls), .ovr_en(ovr_en), .ovr_val(ovr_val),
  .reg_stable(reg_stable), .hw_en(hw_en), .en_out(en_out), .sleep_req(sleep_req),
  .asleep(asleep), .active(active), .seq_err(seq_err)
);

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wake_req = 0, sleep_req = 0, start_done = 0, stb_on_cfg = 0;
  logic [1:0] pmode = 0;
  logic [5:0] set_pls = 0, clr_pls = 0, slp_off = 0, ovr_en = 0, ovr_val = 0;
  logic [5:0] stab_mask = 6'h3f, man_stb = 0, reg_stable;
  logic [7:0] tmo_limit = 8'd60;
  logic [5:0] en_out, en_rdbk;
  logic       asleep, active, seq_err;
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign reg_stable = (en_out & stab_mask) | man_stb;

  pwr_seq_ctrl u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req),
    .start_done(start_done), .pmode(pmode), .set_pls(set_pls), .clr_pls(clr_pls),
    .slp_off(slp_off), .stb_on_cfg(stb_on_cfg), .reg_stable(reg_stable),
    .tmo_limit(tmo_limit), .ovr_en(ovr_en), .ovr_val(ovr_val), .en_out(en_out),
    .en_rdbk(en_rdbk), .asleep(asleep), .active(active), .seq_err(seq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse_wake();   wake_req = 1;   step(1); wake_req = 0;   endtask
  task automatic pulse_sleep();  sleep_req = 1;  step(1); sleep_req = 0;  endtask
  task automatic pulse_done();   start_done = 1; step(1); start_done = 0; endtask

  task automatic t_reset();
    do_reset();
    chk("R1 en_out", en_out, 6'b100000);
    chk("R12 rdbk", en_rdbk, 6'b100000);
    chk("R1 asleep", asleep, 1);
    chk("R1 active", active, 0);
    chk("R1 err", seq_err, 0);
  endtask

  task automatic t_wake_mode(input logic [1:0] pm);
    logic [5:0] exp_w;
    pmode = pm;
    exp_w = 6'b101100;
    exp_w[0] = (pm != 2'd1);
    exp_w[1] = (pm != 2'd0);
    pulse_wake();
    step(15);
    chk($sformatf("R2 R4 wake pm%0d", pm), en_out, exp_w);
    chk("R3 not active before done", active, 0);
    pulse_done();
    step(3);
    if (pm == 2'd2) exp_w[1] = 1'b0;
    chk($sformatf("R3 after done pm%0d", pm), en_out, exp_w);
    chk("R3 active", active, 1);
    slp_off = 6'b011111;
    pulse_sleep();
    step(3);
    chk("R6 sleep drop", en_out, 6'b100000);
    chk("R6 asleep", asleep, 1);
  endtask

  task automatic t_setclr();
    pmode = 2'd0;
    pulse_wake(); step(15); pulse_done(); step(3);
    set_pls = 6'b000010; step(1); set_pls = 0;
    step(1);
    chk("R5 set", en_out, 6'b101111);
    clr_pls = 6'b000001; step(1); clr_pls = 0;
    step(1);
    chk("R5 clear", en_out, 6'b101110);
    set_pls = 6'b000100; clr_pls = 6'b000100; step(1); set_pls = 0; clr_pls = 0;
    step(1);
    chk("R5 clear wins", en_out, 6'b101010);
    slp_off = 6'b011111;
    pulse_sleep(); step(3);
    chk("R6 sleep after sw", en_out, 6'b100000);
  endtask

  task automatic t_handover();
    pmode = 2'd3;
    pulse_wake(); step(15); pulse_done(); step(3);
    chk("R3 pm3 both on", en_out, 6'b101111);
    slp_off = 6'b001011; stb_on_cfg = 1; stab_mask[4] = 0;
    pulse_sleep(); step(10);
    chk("R7 stb up mio held", en_out, 6'b111111);
    chk("R7 not asleep", asleep, 0);
    man_stb[4] = 1; step(3); man_stb[4] = 0;
    step(8);
    chk("R9 short stable ignored", en_out, 6'b111111);
    stab_mask[4] = 1; step(10);
    chk("R7 mio dropped after stb", en_out, 6'b110100);
    chk("R7 asleep", asleep, 1);
    stab_mask[3] = 0;
    pulse_wake(); step(10);
    chk("R8 stb held during wake", en_out, 6'b111111);
    stab_mask[3] = 1; step(10);
    chk("R8 stb released", en_out, 6'b101111);
    pulse_done(); step(3);
    chk("R8 active", active, 1);
    stb_on_cfg = 0;
  endtask

  task automatic t_override();
    ovr_en = 6'b000100; ovr_val = 6'b000000; step(1);
    chk("R11 force off", en_out, 6'b101011);
    ovr_en = 6'b110100; ovr_val = 6'b010000; step(1);
    chk("R11 mixed", en_out, 6'b011011);
    chk("R12 rdbk", en_rdbk, 6'b011011);
    ovr_en = 0; ovr_val = 0; step(1);
    chk("R11 release", en_out, 6'b101111);
  endtask

  task automatic t_timeout();
    do_reset();
    tmo_limit = 8'd30; stab_mask[3] = 0; pmode = 2'd0;
    pulse_wake(); step(80);
    chk("R10 err", seq_err, 1);
    chk("R10 en frozen", en_out, 6'b101101);
    pulse_sleep(); pulse_done(); step(5);
    chk("R10 en still", en_out, 6'b101101);
    chk("R10 not active", active, 0);
    chk("R10 not asleep", asleep, 0);
    stab_mask = 6'h3f; tmo_limit = 8'd60;
  endtask

  initial begin
    t_reset();
    for (int m = 0; m < 4; m++) t_wake_mode(m[1:0]);
    t_setclr();
    t_handover();
    t_override();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500us;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule